// File: doc/BRIEF.md
# Two-Phase Nonoverlapping Clock Generator

This block turns a fast reference clock into two slower clock phases for designs built from latches or split-phase storage, where capture and release happen on different phases. The two phases take turns and are never high together. The low gap between the end of one phase and the start of the other is whatever the period leaves after the two high times. Narrowing the high times therefore widens the gap, and this can be done at run time. This is how a hold problem found on silicon is tuned out without a new mask.

All timing is counted in reference-clock cycles. Three inputs set the period P, the phase-1 high time H1 and the phase-2 high time H2. Phase 1 rises at the start of each period. Phase 2 rises floor(P/2) cycles later, so with H1 = H2 = P/4 each phase has a 25% duty cycle and the two pulses sit 180 degrees apart. The counter is 16 bits wide by default. A 50 kHz output from a reference of a few MHz therefore fits easily. For example, P = 80 at 4 MHz gives 50 kHz.

A controller with five named states sequences the period: RESET, PH1 (phase 1 high), GAP1 (both low), PH2 (phase 2 high) and GAP2 (both low). The transitions are RESET to PH1 on the first edge without reset, PH1 to GAP1, GAP1 to PH2, PH2 to GAP2 and GAP2 to PH1. Each state is left when its down-counter reaches zero. Asserting reset returns the controller to RESET from any state. The configuration is sampled on the RESET-to-PH1 and GAP2-to-PH1 transitions only. All three outputs come straight from flip-flops.

Top module: `nov_clkgen`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge of `clk_ref`, all three outputs are low after that edge.
- R2: On the first edge with `rst` low, `phase1` and `phase1_stb` go high, so phase 1 always pulses before phase 2.
- R3: `phase1` and `phase2` are never high in the same cycle.
- R4: `phase1` stays high for exactly H1 cycles, counted from the period-start edge.
- R5: `phase2` rises floor(P/2) cycles after `phase1` rises in the same period.
- R6: `phase2` stays high for exactly H2 cycles.
- R7: Successive rising edges of `phase1` are exactly P cycles apart.
- R8: The configuration inputs are sampled only on the period-start edge, where `phase1` rises. Changes at any other time have no effect until the next period start.
- R9: A high time of 0 is treated as 1. H1 is limited to floor(P/2)-1 and H2 to P-floor(P/2)-1. This keeps at least one cycle in which both phases are low before each rising edge.
- R10: A period below 4 is treated as 4.
- R11: `phase1_stb` is high for exactly one cycle, the first cycle of every `phase1` pulse, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; every duration is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Period P in reference cycles |
| cfg_high1 | input | CNT_W | Phase-1 high time H1 in reference cycles |
| cfg_high2 | input | CNT_W | Phase-2 high time H2 in reference cycles |
| phase1 | output | 1 | Phase-1 clock, registered |
| phase2 | output | 1 | Phase-2 clock, registered |
| phase1_stb | output | 1 | One-cycle pulse marking each phase-1 rising edge |

## Verification
Every output is registered one edge after the state it reflects. The value the block presents after edge k of a period, counting the period-start edge as k = 0, is phase1 = (k < H1), phase2 = (floor(P/2) <= k < floor(P/2)+H2) and strobe = (k == 0), all after clamping. The driver sets the inputs half a cycle before the edge that is to sample them. It then queues one expected triple for each edge of the coming period, or for each edge of a reset burst. The monitor pops one entry 1 ns after every rising edge, so each result is compared in exactly the cycle it is due. Configuration changes made in the middle of a period are queued against the values latched at its start.

// File: rtl/nov_clkgen_pkg.sv
package nov_clkgen_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_PH1   = 3'd1,
        ST_GAP1  = 3'd2,
        ST_PH2   = 3'd3,
        ST_GAP2  = 3'd4
    } nov_state_e;

    // Slots of the segment-length vector, in sequence order.
    localparam int SEG_PH1  = 0;
    localparam int SEG_GAP1 = 1;
    localparam int SEG_PH2  = 2;
    localparam int SEG_GAP2 = 3;
    localparam int SEG_N    = 4;

    // Shortest period that leaves one high and one low cycle per phase.
    localparam int MIN_PERIOD = 4;

endpackage

// File: rtl/nov_cfg_clamp.sv
// Turns raw period / high-time settings into four legal segment lengths.
module nov_cfg_clamp
    import nov_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]            period_raw,
    input  logic [CNT_W-1:0]            high1_raw,
    input  logic [CNT_W-1:0]            high2_raw,
    output logic [SEG_N-1:0][CNT_W-1:0] seg_len
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] half_a;
    logic [CNT_W-1:0] half_b;
    logic [CNT_W-1:0] h1;
    logic [CNT_W-1:0] h2;

    always_comb begin
        per    = (period_raw < MIN_P) ? MIN_P : period_raw;
        half_a = per >> 1;
        half_b = per - half_a;

        if (high1_raw == '0)
            h1 = ONE;
        else if (high1_raw > half_a - ONE)
            h1 = half_a - ONE;
        else
            h1 = high1_raw;

        if (high2_raw == '0)
            h2 = ONE;
        else if (high2_raw > half_b - ONE)
            h2 = half_b - ONE;
        else
            h2 = high2_raw;

        seg_len[SEG_PH1]  = h1;
        seg_len[SEG_GAP1] = half_a - h1;
        seg_len[SEG_PH2]  = h2;
        seg_len[SEG_GAP2] = half_b - h2;
    end

endmodule

// File: rtl/nov_cfg_shadow.sv
// Holds the segment lengths of the running period; passes live values on load.
module nov_cfg_shadow
    import nov_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [SEG_N-1:0][CNT_W-1:0] len_live,
    output logic [SEG_N-1:0][CNT_W-1:0] len_use
);

    logic [SEG_N-1:0][CNT_W-1:0] len_q;

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                len_q[g] <= '0;
            else if (load)
                len_q[g] <= len_live[g];
        end

        assign len_use[g] = load ? len_live[g] : len_q[g];
    end

endmodule

// File: rtl/nov_phase_fsm.sv
// Sequencer: RESET -> PH1 -> GAP1 -> PH2 -> GAP2 -> PH1 ...
module nov_phase_fsm
    import nov_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SEG_N-1:0][CNT_W-1:0] seg_len,
    output logic                        load,
    output logic                        ph1_o,
    output logic                        ph2_o,
    output logic                        stb_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    nov_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and segment counter.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q - ONE;
        load  = 1'b0;
        unique case (st_q)
            ST_RESET: begin
                st_d  = ST_PH1;
                cnt_d = seg_len[SEG_PH1] - ONE;
                load  = 1'b1;
            end
            ST_PH1: begin
                if (cnt_q == '0) begin
                    st_d  = ST_GAP1;
                    cnt_d = seg_len[SEG_GAP1] - ONE;
                end
            end
            ST_GAP1: begin
                if (cnt_q == '0) begin
                    st_d  = ST_PH2;
                    cnt_d = seg_len[SEG_PH2] - ONE;
                end
            end
            ST_PH2: begin
                if (cnt_q == '0) begin
                    st_d  = ST_GAP2;
                    cnt_d = seg_len[SEG_GAP2] - ONE;
                end
            end
            ST_GAP2: begin
                if (cnt_q == '0) begin
                    st_d  = ST_PH1;
                    cnt_d = seg_len[SEG_PH1] - ONE;
                    load  = 1'b1;
                end
            end
            default: begin
                st_d  = ST_RESET;
                cnt_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RESET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph1_o <= 1'b0;
            ph2_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            ph1_o <= (st_d == ST_PH1);
            ph2_o <= (st_d == ST_PH2);
            stb_o <= (st_d == ST_PH1) && (st_q != ST_PH1);
        end
    end

endmodule

// File: rtl/nov_clkgen.sv
module nov_clkgen
    import nov_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_high1,
    input  logic [CNT_W-1:0] cfg_high2,
    output logic             phase1,
    output logic             phase2,
    output logic             phase1_stb
);

    logic [SEG_N-1:0][CNT_W-1:0] len_live;
    logic [SEG_N-1:0][CNT_W-1:0] len_use;
    logic                        seg_load;

    nov_cfg_clamp #(.CNT_W(CNT_W)) u_clamp (
        .period_raw (cfg_period),
        .high1_raw  (cfg_high1),
        .high2_raw  (cfg_high2),
        .seg_len    (len_live)
    );

    nov_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk_ref),
        .rst      (rst),
        .load     (seg_load),
        .len_live (len_live),
        .len_use  (len_use)
    );

    nov_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk_ref),
        .rst     (rst),
        .seg_len (len_use),
        .load    (seg_load),
        .ph1_o   (phase1),
        .ph2_o   (phase2),
        .stb_o   (phase1_stb)
    );

endmodule

// File: rtl/nov_clkgen_chk.sv
module nov_clkgen_chk (
    input logic clk,
    input logic rst,
    input logic ph1,
    input logic ph2,
    input logic stb
);

    AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!ph1 && !ph2 && !stb)); // R1

    AST_FIRST_PH1: assert property (@(posedge clk) disable iff (rst) $fell(rst) |=> (ph1 && stb && !ph2)); // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(ph1 && ph2)); // R3

    AST_GAP_BEFORE_PH2: assert property (@(posedge clk) disable iff (rst) $rose(ph2) |-> !$past(ph1)); // R9

    AST_GAP_BEFORE_PH1: assert property (@(posedge clk) disable iff (rst) $rose(ph1) |-> !$past(ph2)); // R9

    AST_STB_IN_PH1: assert property (@(posedge clk) disable iff (rst) stb |-> ph1); // R11

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) stb |=> !stb); // R11

    AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(ph1) |-> stb); // R11

endmodule

bind nov_clkgen nov_clkgen_chk u_chk (
    .clk (clk_ref),
    .rst (rst),
    .ph1 (phase1),
    .ph2 (phase2),
    .stb (phase1_stb)
);

// File: tb/nov_clkgen_bench.sv
`timescale 1ns/1ps
module nov_clkgen_bench;

    localparam int CNT_W = 16;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic  p1;
        logic  p2;
        logic  sb;
        string req;
    } exp_t;

    logic             clk_ref = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_period = '0;
    logic [CNT_W-1:0] cfg_high1 = '0;
    logic [CNT_W-1:0] cfg_high2 = '0;
    logic             phase1;
    logic             phase2;
    logic             phase1_stb;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   n_cycles = 0;
    bit   done = 1'b0;

    always #4 clk_ref = ~clk_ref;

    nov_clkgen #(.CNT_W(CNT_W)) u_nov_clkgen (
        .clk_ref    (clk_ref),
        .rst        (rst),
        .cfg_period (cfg_period),
        .cfg_high1  (cfg_high1),
        .cfg_high2  (cfg_high2),
        .phase1     (phase1),
        .phase2     (phase2),
        .phase1_stb (phase1_stb)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Driver: reset burst; expects all-low outputs (R1).
    task automatic drive_reset(int n);
        exp_t e;
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            e.p1 = 1'b0; e.p2 = 1'b0; e.sb = 1'b0; e.req = "R1";
            q.push_back(e);
        end
        repeat (n) @(negedge clk_ref);
    endtask

    // Driver: one full period; optional junk config after the start edge (R8).
    task automatic drive_period(int p, int h1, int h2, string req, bit junk);
        int   pe, ha, hb, e1, e2;
        exp_t e;
        rst        = 1'b0;
        cfg_period = CNT_W'(p);
        cfg_high1  = CNT_W'(h1);
        cfg_high2  = CNT_W'(h2);
        pe = (p < 4) ? 4 : p;                       // R10
        ha = pe / 2;
        hb = pe - ha;
        e1 = (h1 == 0) ? 1 : ((h1 > ha - 1) ? ha - 1 : h1);  // R9
        e2 = (h2 == 0) ? 1 : ((h2 > hb - 1) ? hb - 1 : h2);  // R9
        for (int k = 0; k < pe; k++) begin
            e.p1  = (k < e1);                        // R4
            e.p2  = (k >= ha) && (k < ha + e2);      // R5 R6
            e.sb  = (k == 0);                        // R11
            e.req = req;
            q.push_back(e);
        end
        @(negedge clk_ref);
        if (junk) begin
            cfg_period = CNT_W'(30);
            cfg_high1  = CNT_W'(1);
            cfg_high2  = CNT_W'(9);
        end
        repeat (pe - 1) @(negedge clk_ref);
    endtask

    // Monitor: one expected entry per rising edge, sampled 1 ns after it.
    initial begin
        forever begin
            @(posedge clk_ref);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (phase1 !== e.p1 || phase2 !== e.p2) begin
                    n_errors++;
                    $display("FAIL %s: phase1/phase2 = %b%b, expected %b%b at %0t",
                             e.req, phase1, phase2, e.p1, e.p2, $time);
                end
                n_checks++;
                if (phase1_stb !== e.sb) begin
                    n_errors++;
                    $display("FAIL R11 (%s): phase1_stb = %b, expected %b at %0t",
                             e.req, phase1_stb, e.sb, $time);
                end
                n_checks++;
                if (phase1 === 1'b1 && phase2 === 1'b1) begin
                    n_errors++;
                    $display("FAIL R3: phases overlap, actual 11 expected not 11 at %0t", $time);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk_ref);
            n_cycles++;
            if (n_cycles > WATCHDOG && !done) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog: cycles = %0d, expected <= %0d", n_cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        @(negedge clk_ref);
        drive_reset(3);                          // R1
        drive_period(8, 2, 2, "R2", 1'b0);       // first pulse after release
        drive_period(8, 2, 2, "R4", 1'b0);       // 25% duty, 180 degrees
        drive_period(12, 3, 2, "R6", 1'b0);      // unequal high times
        drive_period(11, 2, 4, "R5", 1'b0);      // odd period, phase-2 offset
        drive_period(16, 4, 4, "R7", 1'b0);      // longer period
        drive_period(10, 3, 3, "R8", 1'b1);      // mid-period change ignored
        drive_period(10, 3, 3, "R8", 1'b0);
        drive_period(10, 9, 9, "R9", 1'b0);      // high times clamped
        drive_period(6, 0, 0, "R9", 1'b0);       // zero high time
        drive_period(2, 1, 1, "R10", 1'b0);      // short period raised to 4
        drive_period(9, 2, 2, "R7", 1'b0);
        drive_reset(2);                          // R1 mid-run
        drive_period(8, 2, 2, "R2", 1'b0);
        while (q.size() > 0) @(negedge clk_ref);
        @(negedge clk_ref);
        done = 1'b1;
        summary();
    end

endmodule